// File: doc/BRIEF.md
# Paired-Rank Fractional Shift Unit

This block performs the shift instructions of a 40-bit fractional machine. Values are two's complement, with the sign in the top bit and the binary point just below it, so every word lies between -1 and +1. The accumulator (R1) and the arithmetic register (R2) are each built from two ranks: a permanent rank, which is visible at the outputs, and a hidden temporary rank. A single-bit shift happens only when data moves from the temporary rank back to the permanent one. The move from permanent to temporary is a plain copy. A shift of N places therefore runs N such two-cycle steps. The memory register (R3) receives the value R2 held before the shift.

Two shift kinds are supported. The right shift treats R1 and R2 as one 80-bit register and keeps the sign. The left shift moves R1 and R2 separately, and the current sign of R1 enters the low end of both. A clear flag that comes with the instruction zeroes R1 before a right shift. For a left shift it zeroes R1 once the shift ends and stops the sign from entering R2. A count that is out of range is refused: the block raises a one-cycle flag and leaves every register as it was. Surrounding logic fills the registers through the load ports while the unit is idle.

Top module: `rank_shift_unit`

## Requirements
- R1: While reset is held, and after reset is released, r1, r2 and r3 read zero and busy, done and bad_cnt are low.
- R2: While the unit is idle and start is low, load_r1, load_r2 and load_r3 each write load_data into their register at the next clock edge. Loads are ignored while busy is high and in a cycle where start is high.
- R3: A start that is accepted copies the value r2 had before the shift into r3 at the accepting edge. r3 then stays unchanged until the shift ends.
- R4: Right shift (op_left = 0, clr_digit = 0) shifts the 80-bit value {r1, r2} arithmetically right by N places. Bit 0 of r1 enters bit 39 of r2, and bit 39 of r1 is kept at every step.
- R5: A right shift with clr_digit = 1 zeroes r1 at the accepting edge and then shifts as R4 describes, so the result is {r1, r2} = {40'b0, r2} shifted right by N.
- R6: Left shift (op_left = 1, clr_digit = 0) shifts r1 and r2 separately left by one place per step. At each step, bit 39 of r1 before that step enters bit 0 of both r1 and r2.
- R7: A left shift with clr_digit = 1 feeds 0 into bit 0 of r2 at every step and leaves r1 at zero once the last step is done.
- R8: The shift count N is shift_cnt (6 bits). After an accepted start, busy is high for 2N+1 cycles. r1 and r2 change only on every second edge, at edges 2, 4, ..., 2N after the accepting edge. done is high for exactly the final busy cycle.
- R9: A start with N = 0 or N >= 47 raises bad_cnt for the one following cycle, does not raise busy, and leaves r1, r2 and r3 unchanged.
- R10: A start while busy is high is ignored. It changes neither the shift in progress nor its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a shift using op_left, shift_cnt and clr_digit |
| op_left | input | 1 | 1 = left shift, 0 = right shift |
| shift_cnt | input | 6 | Number of places N; legal values are 1 to 46 |
| clr_digit | input | 1 | Clear flag of the instruction |
| load_r1 | input | 1 | Write load_data into R1 when idle |
| load_r2 | input | 1 | Write load_data into R2 when idle |
| load_r3 | input | 1 | Write load_data into R3 when idle |
| load_data | input | 40 | Data for register loads |
| r1 | output | 40 | Permanent rank of the accumulator |
| r2 | output | 40 | Permanent rank of the arithmetic register |
| r3 | output | 40 | Memory register |
| busy | output | 1 | A shift is in progress |
| done | output | 1 | Final cycle of a shift |
| bad_cnt | output | 1 | One-cycle pulse after a refused start |

## Verification
The assertions check rules that must hold on every cycle. done lasts one cycle and ends the busy period. A refused count freezes all three registers and keeps busy low. r3 holds still during a shift. The sign of r1 never moves during a right shift that is not cleared. r1 is zero at the end of a cleared left shift. The bit-level results can only be shown by the bench's scenarios: the 80-bit arithmetic right shift, the sign fed into both low ends, the zero fed into r2 when clearing, the exact step edges for counts up to 46, and starts and loads that are ignored while busy.

// File: rtl/rsu_pkg.sv
package rsu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_COPY = 2'd1,
    ST_XFER = 2'd2,
    ST_FIN  = 2'd3
  } rsu_state_e;
endpackage

// File: rtl/rsu_rst_sync.sv
module rsu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/rsu_rank_pair.sv
module rsu_rank_pair #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         perm_we,
  input  logic [W-1:0] perm_d,
  input  logic         tmp_we,
  output logic [W-1:0] perm_q,
  output logic [W-1:0] tmp_q
);
  logic [W-1:0] perm_nxt, tmp_nxt;

  always_comb begin
    perm_nxt = perm_we ? perm_d : perm_q;
    tmp_nxt  = tmp_we  ? perm_q : tmp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perm_q <= '0;
      tmp_q  <= '0;
    end else begin
      perm_q <= perm_nxt;
      tmp_q  <= tmp_nxt;
    end
  end
endmodule

// File: rtl/rsu_step.sv
module rsu_step #(
  parameter int W = 40
) (
  input  logic         go_left,
  input  logic         clr,
  input  logic [W-1:0] hi_tmp,
  input  logic [W-1:0] lo_tmp,
  output logic [W-1:0] hi_nxt,
  output logic [W-1:0] lo_nxt
);
  logic sgn;

  always_comb begin
    sgn = hi_tmp[W-1];
    if (go_left) begin
      hi_nxt = {hi_tmp[W-2:0], sgn};
      lo_nxt = {lo_tmp[W-2:0], sgn & ~clr};
    end else begin
      hi_nxt = {sgn, hi_tmp[W-1:1]};
      lo_nxt = {hi_tmp[0], lo_tmp[W-1:1]};
    end
  end
endmodule

// File: rtl/rsu_seq.sv
module rsu_seq
  import rsu_pkg::*;
#(
  parameter int CW    = 6,
  parameter int LIMIT = 47
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_left,
  input  logic          clr_digit,
  input  logic [CW-1:0] shift_cnt,
  output logic          busy,
  output logic          done,
  output logic          bad_cnt,
  output logic          accept,
  output logic          copy_en,
  output logic          xfer_en,
  output logic          last_step,
  output logic          mode_left,
  output logic          mode_clr
);
  rsu_state_e    state_q, state_d;
  logic [CW-1:0] rem_q, rem_d;
  logic          rem_en, legal, idle;
  logic          bad_d;

  always_comb begin
    idle      = (state_q == ST_IDLE);
    legal     = (shift_cnt != '0) && (shift_cnt < CW'(LIMIT));
    accept    = idle && start && legal;
    bad_d     = idle && start && !legal;
    copy_en   = (state_q == ST_COPY);
    xfer_en   = (state_q == ST_XFER);
    last_step = xfer_en && (rem_q == CW'(1));
    rem_en    = accept || xfer_en;
    rem_d     = accept ? shift_cnt : rem_q - CW'(1);
    state_d   = state_q;
    case (state_q)
      ST_IDLE: if (accept)    state_d = ST_COPY;
      ST_COPY:                state_d = ST_XFER;
      ST_XFER: if (last_step) state_d = ST_FIN;
               else           state_d = ST_COPY;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      rem_q     <= '0;
      mode_left <= 1'b0;
      mode_clr  <= 1'b0;
      bad_cnt   <= 1'b0;
    end else begin
      state_q <= state_d;
      bad_cnt <= bad_d;
      if (rem_en) rem_q <= rem_d;
      if (accept) begin
        mode_left <= op_left;
        mode_clr  <= clr_digit;
      end
    end
  end

  assign busy = !idle;
  assign done = (state_q == ST_FIN);
endmodule

// File: rtl/rank_shift_unit.sv
module rank_shift_unit #(
  parameter int W     = 40,
  parameter int CW    = 6,
  parameter int LIMIT = 47
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_left,
  input  logic [CW-1:0] shift_cnt,
  input  logic          clr_digit,
  input  logic          load_r1,
  input  logic          load_r2,
  input  logic          load_r3,
  input  logic [W-1:0]  load_data,
  output logic [W-1:0]  r1,
  output logic [W-1:0]  r2,
  output logic [W-1:0]  r3,
  output logic          busy,
  output logic          done,
  output logic          bad_cnt
);
  localparam int NRANK = 2;

  logic         rst_q_n;
  logic         accept, copy_en, xfer_en, last_step, mode_left, mode_clr;
  logic         load_ok;
  logic [W-1:0] perm_q [NRANK];
  logic [W-1:0] tmp_q  [NRANK];
  logic [W-1:0] perm_d [NRANK];
  logic         perm_we[NRANK];
  logic [W-1:0] step_q [NRANK];
  logic         ld_sel [NRANK];
  logic [W-1:0] r3_q, r3_d;
  logic         r3_we;

  rsu_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_q_n)
  );

  rsu_seq #(.CW(CW), .LIMIT(LIMIT)) u_seq (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .start    (start),
    .op_left  (op_left),
    .clr_digit(clr_digit),
    .shift_cnt(shift_cnt),
    .busy     (busy),
    .done     (done),
    .bad_cnt  (bad_cnt),
    .accept   (accept),
    .copy_en  (copy_en),
    .xfer_en  (xfer_en),
    .last_step(last_step),
    .mode_left(mode_left),
    .mode_clr (mode_clr)
  );

  rsu_step #(.W(W)) u_step (
    .go_left(mode_left),
    .clr    (mode_clr),
    .hi_tmp (tmp_q[0]),
    .lo_tmp (tmp_q[1]),
    .hi_nxt (step_q[0]),
    .lo_nxt (step_q[1])
  );

  assign load_ok   = !busy && !start;
  assign ld_sel[0] = load_r1;
  assign ld_sel[1] = load_r2;

  // index 0 is the accumulator, index 1 the arithmetic register
  for (genvar g = 0; g < NRANK; g++) begin : g_rank
    logic clr_here;
    always_comb begin
      clr_here = 1'b0;
      if (g == 0) begin
        clr_here = (accept && !op_left && clr_digit) ||
                   (last_step && mode_left && mode_clr);
      end
      if (clr_here) begin
        perm_we[g] = 1'b1;
        perm_d[g]  = '0;
      end else if (xfer_en) begin
        perm_we[g] = 1'b1;
        perm_d[g]  = step_q[g];
      end else if (load_ok && ld_sel[g]) begin
        perm_we[g] = 1'b1;
        perm_d[g]  = load_data;
      end else begin
        perm_we[g] = 1'b0;
        perm_d[g]  = perm_q[g];
      end
    end

    rsu_rank_pair #(.W(W)) u_pair (
      .clk    (clk),
      .rst_n  (rst_q_n),
      .perm_we(perm_we[g]),
      .perm_d (perm_d[g]),
      .tmp_we (copy_en),
      .perm_q (perm_q[g]),
      .tmp_q  (tmp_q[g])
    );
  end

  always_comb begin
    r3_we = accept || (load_ok && load_r3);
    r3_d  = accept ? perm_q[1] : load_data;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)   r3_q <= '0;
    else if (r3_we) r3_q <= r3_d;
  end

  assign r1 = perm_q[0];
  assign r2 = perm_q[1];
  assign r3 = r3_q;
endmodule

// File: rtl/rsu_chk.sv
module rsu_chk #(
  parameter int W = 40
) (
  input logic         clk,
  input logic         rst_n,
  input logic         busy,
  input logic         done,
  input logic         bad_cnt,
  input logic         mode_left,
  input logic         mode_clr,
  input logic [W-1:0] r1,
  input logic [W-1:0] r2,
  input logic [W-1:0] r3
);
  // R8
  done_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R9
  refused_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_cnt |-> ($stable(r1) && $stable(r2) && $stable(r3) && !busy));

  // R3
  r3_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$rose(busy)) |-> $stable(r3));

  // R4
  right_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$rose(busy) && !mode_left) |-> $stable(r1[W-1]));

  // R7
  left_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_left && mode_clr) |-> (r1 == '0));
endmodule

bind rank_shift_unit rsu_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_q_n),
  .busy     (busy),
  .done     (done),
  .bad_cnt  (bad_cnt),
  .mode_left(mode_left),
  .mode_clr (mode_clr),
  .r1       (r1),
  .r2       (r2),
  .r3       (r3)
);

// File: tb/rank_shift_unit_bench.sv
module rank_shift_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, op_left = 1'b0, clr_digit = 1'b0;
  logic [5:0]  shift_cnt = '0;
  logic        load_r1 = 1'b0, load_r2 = 1'b0, load_r3 = 1'b0;
  logic [39:0] load_data = '0;
  logic [39:0] r1, r2, r3;
  logic        busy, done, bad_cnt;

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  rank_shift_unit u_rank_shift_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .op_left(op_left),
    .shift_cnt(shift_cnt), .clr_digit(clr_digit),
    .load_r1(load_r1), .load_r2(load_r2), .load_r3(load_r3),
    .load_data(load_data), .r1(r1), .r2(r2), .r3(r3),
    .busy(busy), .done(done), .bad_cnt(bad_cnt)
  );

  // behavioural reference
  logic [39:0] m_r1 = '0, m_r2 = '0, m_r3 = '0;
  logic [79:0] m_cat;
  logic        m_act = 0, m_done = 0, m_bad = 0, m_left = 0, m_clr = 0, m_s;
  int          m_cyc = 0, m_n = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_r1 = '0; m_r2 = '0; m_r3 = '0;
      m_act = 0; m_done = 0; m_bad = 0;
    end else begin
      m_done = 0; m_bad = 0;
      if (m_act) begin
        m_cyc++;
        if (m_cyc % 2 == 0 && m_cyc <= 2 * m_n) begin
          if (m_left) begin
            m_s  = m_r1[39];
            m_r1 = {m_r1[38:0], m_s};
            m_r2 = {m_r2[38:0], m_clr ? 1'b0 : m_s};
          end else begin
            m_cat = $signed({m_r1, m_r2}) >>> 1;
            m_r1  = m_cat[79:40];
            m_r2  = m_cat[39:0];
          end
        end
        if (m_cyc == 2 * m_n) begin
          m_done = 1;
          if (m_left && m_clr) m_r1 = '0;
        end
        if (m_cyc == 2 * m_n + 1) m_act = 0;
      end else if (start) begin
        if (shift_cnt == 0 || shift_cnt >= 47) m_bad = 1;
        else begin
          m_act = 1; m_cyc = 0; m_n = int'(shift_cnt);
          m_left = op_left; m_clr = clr_digit;
          m_r3 = m_r2;
          if (!op_left && clr_digit) m_r1 = '0;
        end
      end else begin
        if (load_r1) m_r1 = load_data;
        if (load_r2) m_r2 = load_data;
        if (load_r3) m_r3 = load_data;
      end
    end
  end

  task automatic chk(string what, logic [39:0] act, logic [39:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h (t=%0t)", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    chk("r1", r1, m_r1);
    chk("r2", r2, m_r2);
    chk("r3", r3, m_r3);
    chk("busy", {39'b0, busy}, {39'b0, m_act});
    chk("done", {39'b0, done}, {39'b0, m_done});
    chk("bad_cnt", {39'b0, bad_cnt}, {39'b0, m_bad});
  end

  task automatic load(input logic [39:0] a, input logic [39:0] b, input logic [39:0] c);
    @(negedge clk); load_data = a; load_r1 = 1;
    @(negedge clk); load_r1 = 0; load_data = b; load_r2 = 1;
    @(negedge clk); load_r2 = 0; load_data = c; load_r3 = 1;
    @(negedge clk); load_r3 = 0;
  endtask

  task automatic shift(input logic l, input logic c, input int n);
    @(negedge clk); start = 1; op_left = l; clr_digit = c; shift_cnt = 6'(n);
    @(negedge clk); start = 0;
    while (m_act) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    cur_req = "R2";
    load(40'h12_3456_789A, 40'hF0F0_0F0F_55, 40'hAB_CDEF_0123);
    cur_req = "R4";
    load(40'h80_0000_0001, 40'h00_0000_0003, 40'h0);
    shift(0, 0, 1);
    shift(0, 0, 46);
    load(40'h40_0000_0007, 40'hC3_0000_00A5, 40'h0);
    shift(0, 0, 13);
    cur_req = "R5";
    load(40'hFF_FFFF_FFFF, 40'h80_1234_5678, 40'h0);
    shift(0, 1, 5);
    cur_req = "R6";
    load(40'hA0_0000_0001, 40'h00_FFFF_0000, 40'h0);
    shift(1, 0, 3);
    load(40'h5A_5A5A_5A5A, 40'h12_3456_789A, 40'h0);
    shift(1, 0, 40);
    cur_req = "R7";
    load(40'hC0_0000_0011, 40'h7F_0000_0001, 40'h0);
    shift(1, 1, 7);
    cur_req = "R3";
    load(40'h01_0203_0405, 40'h99_8877_6655, 40'h0);
    shift(1, 0, 2);
    cur_req = "R9";
    shift(0, 0, 0);
    shift(1, 1, 47);
    shift(0, 1, 63);
    cur_req = "R8";
    shift(0, 0, 46);
    cur_req = "R10";
    load(40'h87_6543_2100, 40'h11_1111_1111, 40'h22);
    @(negedge clk); start = 1; op_left = 0; clr_digit = 0; shift_cnt = 6'd9;
    @(negedge clk); start = 0;
    repeat (3) @(negedge clk);
    start = 1; op_left = 1; clr_digit = 1; shift_cnt = 6'd2;
    load_r1 = 1; load_r3 = 1; load_data = 40'hDE_AD00_BEEF;
    @(negedge clk); start = 0; load_r1 = 0; load_r3 = 0;
    while (m_act) @(negedge clk);
    cur_req = "R2";
    @(negedge clk); start = 1; op_left = 0; shift_cnt = 6'd0; load_r2 = 1; load_data = 40'h33;
    @(negedge clk); start = 0; load_r2 = 0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule